// File: doc/BRIEF.md
# System management interrupt sequencer

This block runs the entry into and the exit from a system management mode. When an external management request arrives while the processor is in normal operation, the block raises an in-mode flag. That flag masks every other interrupt source and switches address generation to a flat 4 GiB space. The block then writes a record of the processor's register state to a dedicated RAM region, one word per cycle, and stores the current region base in a base field below the record. Finally, for one cycle, it hands the core a redirect to the handler entry point, given as a code segment and an instruction pointer.

When the handler issues its resume command, the sequencer reads the record back in the same order and streams every word to the core. It then reads the base field. It reports whether the core should re-enter the halt state, re-execute a trapped I/O instruction, or simply continue at the interrupted instruction. The base value read back on resume becomes the region base for all later entries. This lets the handler move the region during a first visit, and the move takes effect once that visit ends.

The region base resets to 30000h. Every address is the base plus a fixed offset. The record's top word sits at base + FFFCh, the handler is entered at base + 8000h, and the base field sits at base + FEF8h. A request that arrives while the block is already in the mode is held and served immediately after the resume.

Top module: `smi_seq`

## Requirements
- R1: A request on smiIn is accepted only while inSmm is low. From the cycle after acceptance, inSmm stays high until the cycle after resumeDone, masking other interrupts and selecting flat addressing.
- R2: After acceptance the block writes REC_WORDS words on consecutive cycles. Word i goes to base + 10000h − 4·(i+1). Word 0 is the restart-flag word: bit 0 is the halt-restart flag taken from haltIn and bit 1 is the I/O-restart flag taken from ioTrapIn. Each word i > 0 is snapData, with snapIdx = i during that write. With the default base, the record covers 3FFA8h to 3FFFFh.
- R3: In the cycle after the last record word, the block writes the current base to the base field at base + FEF8h.
- R4: In the following cycle, redirValid is high for exactly one cycle, with redirCs = base / 16 and redirIp = 8000h. With the reset base this gives 3000h:8000h.
- R5: No write ever targets the reserved span from base + FE00h to base + FEF7h.
- R6: A resumeStb while in the mode reads record words 0 to REC_WORDS−1 on consecutive cycles and then the base field. memRdata is taken one cycle after memRe. Each record word appears on restoreData, with restoreIdx and restoreValid, one cycle after it is read.
- R7: On resumeDone, resumeKind is 1 (return to halt) when bit 0 of the restored flag word is set, whatever bit 1 holds.
- R8: resumeKind is 2 (re-execute the trapped I/O instruction) when only bit 1 of the restored flag word is set.
- R9: resumeKind is 0 (continue at the interrupted instruction) when neither flag bit is set.
- R10: The base field value read during a resume becomes the base for every later entry, save and redirect. The resume that reads it still uses the old base for all of its own reads.
- R11: A resumeStb while inSmm is low causes no memory access and leaves inSmm low. It sets resumeErr, which stays high until reset.
- R12: A request that arrives while inSmm is high is held. In the cycle after resumeDone, the next save starts at the new base, and inSmm does not drop in between.
- R13: After reset, inSmm, redirValid, memWe, memRe, resumeDone and resumeErr are low, and the base is 30000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| smiIn | input | 1 | Management request strobe |
| resumeStb | input | 1 | Resume command strobe from the handler |
| haltIn | input | 1 | Core was halted when the request arrived |
| ioTrapIn | input | 1 | Core was trapped on an I/O instruction |
| snapIdx | output | $clog2(REC_WORDS) | Register snapshot word selector |
| snapData | input | DATA_W | Selected register snapshot word |
| memAddr | output | ADDR_W | State RAM byte address |
| memWe | output | 1 | State RAM write enable |
| memRe | output | 1 | State RAM read enable, data expected next cycle |
| memWdata | output | DATA_W | State RAM write data |
| memRdata | input | DATA_W | State RAM read data |
| restoreValid | output | 1 | A restored record word is present |
| restoreIdx | output | $clog2(REC_WORDS) | Index of the restored word |
| restoreData | output | DATA_W | Restored word |
| inSmm | output | 1 | In management mode: other interrupts masked, flat addressing |
| redirValid | output | 1 | One-cycle redirect to the handler |
| redirCs | output | 16 | Handler code segment |
| redirIp | output | 16 | Handler instruction pointer |
| resumeDone | output | 1 | One-cycle end of resume |
| resumeKind | output | 2 | 0 continue, 1 halt again, 2 re-execute I/O |
| resumeErr | output | 1 | Sticky flag for a resume outside the mode |

## Verification
The hardest case to reach is a request held across a whole visit and then served back to back with the resume. It needs a second smiIn pulse while the block waits for the handler, followed by a resume, and inSmm must never drop. The bench drives exactly that and checks that the first write of the new save lands in the cycle right after resumeDone. A second hard case is a base move. The bench plays the handler by overwriting the base field and the flag word in its memory model, then checks that the resume still reads the old base field and that the next entry uses the new segment and addresses.

// File: rtl/smi_seq_pkg.sv
package smi_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SAVE, ST_BASEW, ST_REDIR, ST_SMM, ST_RD, ST_RDB, ST_DONE
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic wrRec;
    logic wrBase;
    logic rdRec;
    logic rdBase;
    logic commitBase;
  } seqCtl_t;

  localparam logic [1:0] KIND_CONT = 2'd0;
  localparam logic [1:0] KIND_HALT = 2'd1;
  localparam logic [1:0] KIND_IO   = 2'd2;

endpackage

// File: rtl/smi_seq_ctrl.sv
module smi_seq_ctrl
  import smi_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       smiIn,
  input  logic       resumeStb,
  input  logic       cntLast,
  input  logic [1:0] flags,
  output seqCtl_t    ctl,
  output logic       inSmm,
  output logic       redirValid,
  output logic       resumeDone,
  output logic [1:0] resumeKind,
  output logic       resumeErr
);

  seqState_e state, nextState;
  logic pend;
  logic errQ;

  always_comb begin
    ctl = '0;
    nextState = state;
    case (state)
      ST_IDLE: if (smiIn) begin
        nextState = ST_SAVE;
        ctl.cntClr = 1'b1;
      end
      ST_SAVE: begin
        ctl.wrRec = 1'b1;
        ctl.cntInc = 1'b1;
        if (cntLast) nextState = ST_BASEW;
      end
      ST_BASEW: begin
        ctl.wrBase = 1'b1;
        nextState = ST_REDIR;
      end
      ST_REDIR: nextState = ST_SMM;
      ST_SMM: if (resumeStb) begin
        nextState = ST_RD;
        ctl.cntClr = 1'b1;
      end
      ST_RD: begin
        ctl.rdRec = 1'b1;
        ctl.cntInc = 1'b1;
        if (cntLast) nextState = ST_RDB;
      end
      ST_RDB: begin
        ctl.rdBase = 1'b1;
        nextState = ST_DONE;
      end
      ST_DONE: begin
        ctl.commitBase = 1'b1;
        if (pend || smiIn) begin
          nextState = ST_SAVE;
          ctl.cntClr = 1'b1;
        end else begin
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      pend  <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_DONE) pend <= 1'b0;
      else if (smiIn && state != ST_IDLE) pend <= 1'b1;
      if (resumeStb && state == ST_IDLE) errQ <= 1'b1;
    end
  end

  assign inSmm      = (state != ST_IDLE);
  assign redirValid = (state == ST_REDIR);
  assign resumeDone = (state == ST_DONE);
  assign resumeErr  = errQ;
  assign resumeKind = flags[0] ? KIND_HALT : (flags[1] ? KIND_IO : KIND_CONT);

  // R1: a request seen outside the mode starts the save at once
  a_r1_accept_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!inSmm && smiIn) |=> (state == ST_SAVE));

  // R4: the redirect lasts a single cycle
  a_r4_redir_single: assert property (@(posedge clk) disable iff (!rstN)
    redirValid |=> !redirValid);

  // R11: resume outside the mode raises the error flag and stays outside
  a_r11_resume_err: assert property (@(posedge clk) disable iff (!rstN)
    (resumeStb && !inSmm && !smiIn) |=> (resumeErr && !inSmm));

  // R12: a held request restarts the save right after resume ends
  a_r12_pend_resave: assert property (@(posedge clk) disable iff (!rstN)
    (resumeDone && pend) |=> (state == ST_SAVE));

endmodule

// File: rtl/smi_seq_dp.sv
module smi_seq_dp
  import smi_seq_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned REC_WORDS    = 22,
  parameter int unsigned RESET_BASE   = 'h30000,
  parameter int unsigned ENTRY_OFF    = 'h8000,
  parameter int unsigned REC_END_OFF  = 'h10000,
  parameter int unsigned BASE_FLD_OFF = 'hFEF8,
  parameter int unsigned RESV_LO_OFF  = 'hFE00,
  parameter int unsigned RESV_HI_OFF  = 'hFEF7,
  localparam int unsigned CNT_W       = $clog2(REC_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic              haltIn,
  input  logic              ioTrapIn,
  input  logic [DATA_W-1:0] snapData,
  input  logic [DATA_W-1:0] memRdata,
  output logic [CNT_W-1:0]  snapIdx,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic              memRe,
  output logic [DATA_W-1:0] memWdata,
  output logic              restoreValid,
  output logic [CNT_W-1:0]  restoreIdx,
  output logic [DATA_W-1:0] restoreData,
  output logic [1:0]        flags,
  output logic              cntLast,
  output logic [15:0]       redirCs,
  output logic [15:0]       redirIp
);

  localparam logic [ADDR_W-1:0] REC_END  = ADDR_W'(REC_END_OFF);
  localparam logic [ADDR_W-1:0] BASE_FLD = ADDR_W'(BASE_FLD_OFF);
  localparam logic [ADDR_W-1:0] RESV_LO  = ADDR_W'(RESV_LO_OFF);
  localparam logic [ADDR_W-1:0] RESV_HI  = ADDR_W'(RESV_HI_OFF);

  logic [ADDR_W-1:0] base;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] wordOff;
  logic [ADDR_W-1:0] baseSh;
  logic              rdV;
  logic [CNT_W-1:0]  rdI;
  logic [1:0]        flagQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      base  <= ADDR_W'(RESET_BASE);
      cnt   <= '0;
      rdV   <= 1'b0;
      rdI   <= '0;
      flagQ <= 2'b00;
    end else begin
      if (ctl.cntClr) cnt <= '0;
      else if (ctl.cntInc) cnt <= cnt + 1'b1;
      if (ctl.commitBase) base <= ADDR_W'(memRdata);
      rdV <= ctl.rdRec;
      rdI <= cnt;
      if (rdV && rdI == '0) flagQ <= memRdata[1:0];
    end
  end

  always_comb begin
    wordOff = (ADDR_W'(cnt) + ADDR_W'(1)) << 2;
    if (ctl.wrBase || ctl.rdBase) memAddr = base + BASE_FLD;
    else memAddr = base + REC_END - wordOff;
    if (ctl.wrBase) memWdata = DATA_W'(base);
    else if (cnt == '0) memWdata = DATA_W'({ioTrapIn, haltIn});
    else memWdata = snapData;
    baseSh = base >> 4;
  end

  assign memWe        = ctl.wrRec | ctl.wrBase;
  assign memRe        = ctl.rdRec | ctl.rdBase;
  assign snapIdx      = cnt;
  assign cntLast      = (cnt == CNT_W'(REC_WORDS - 1));
  assign restoreValid = rdV;
  assign restoreIdx   = rdI;
  assign restoreData  = memRdata;
  assign flags        = flagQ;
  assign redirCs      = baseSh[15:0];
  assign redirIp      = 16'(ENTRY_OFF);

  // R5: the reserved span below the base field is never written
  a_r5_resv_untouched: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !((memAddr >= base + RESV_LO) && (memAddr <= base + RESV_HI)));

  // R6: restored words follow a read one cycle later
  a_r6_restore_follows_read: assert property (@(posedge clk) disable iff (!rstN)
    restoreValid |-> $past(memRe));

  // R6: the memory port never reads and writes together
  a_r6_port_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));

  // R10: the base only moves at the end of a resume
  a_r10_base_moves_on_commit: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(base) |-> $past(ctl.commitBase));

endmodule

// File: rtl/smi_seq.sv
module smi_seq
  import smi_seq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned REC_WORDS  = 22,
  parameter int unsigned RESET_BASE = 'h30000,
  parameter int unsigned ENTRY_OFF  = 'h8000
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         smiIn,
  input  logic                         resumeStb,
  input  logic                         haltIn,
  input  logic                         ioTrapIn,
  output logic [$clog2(REC_WORDS)-1:0] snapIdx,
  input  logic [DATA_W-1:0]            snapData,
  output logic [ADDR_W-1:0]            memAddr,
  output logic                         memWe,
  output logic                         memRe,
  output logic [DATA_W-1:0]            memWdata,
  input  logic [DATA_W-1:0]            memRdata,
  output logic                         restoreValid,
  output logic [$clog2(REC_WORDS)-1:0] restoreIdx,
  output logic [DATA_W-1:0]            restoreData,
  output logic                         inSmm,
  output logic                         redirValid,
  output logic [15:0]                  redirCs,
  output logic [15:0]                  redirIp,
  output logic                         resumeDone,
  output logic [1:0]                   resumeKind,
  output logic                         resumeErr
);

  seqCtl_t    ctl;
  logic       cntLast;
  logic [1:0] flags;

  smi_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .smiIn      (smiIn),
    .resumeStb  (resumeStb),
    .cntLast    (cntLast),
    .flags      (flags),
    .ctl        (ctl),
    .inSmm      (inSmm),
    .redirValid (redirValid),
    .resumeDone (resumeDone),
    .resumeKind (resumeKind),
    .resumeErr  (resumeErr)
  );

  smi_seq_dp #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .REC_WORDS  (REC_WORDS),
    .RESET_BASE (RESET_BASE),
    .ENTRY_OFF  (ENTRY_OFF)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .haltIn       (haltIn),
    .ioTrapIn     (ioTrapIn),
    .snapData     (snapData),
    .memRdata     (memRdata),
    .snapIdx      (snapIdx),
    .memAddr      (memAddr),
    .memWe        (memWe),
    .memRe        (memRe),
    .memWdata     (memWdata),
    .restoreValid (restoreValid),
    .restoreIdx   (restoreIdx),
    .restoreData  (restoreData),
    .flags        (flags),
    .cntLast      (cntLast),
    .redirCs      (redirCs),
    .redirIp      (redirIp)
  );

endmodule

// File: tb/test_smi_seq.sv
`timescale 1ns/1ps
module test_smi_seq;

  localparam int REC = 22;

  typedef struct packed {
    logic        halt;
    logic        io;
    logic        pokeEn;
    logic [1:0]  pokeFlags;
    logic [7:0]  seed;
    logic [31:0] newBase;
    logic [1:0]  expKind;
  } vecRow_t;

  localparam vecRow_t VECS [0:5] = '{
    '{halt:1'b1, io:1'b0, pokeEn:1'b0, pokeFlags:2'd0, seed:8'h11, newBase:32'h30000, expKind:2'd1},
    '{halt:1'b0, io:1'b1, pokeEn:1'b0, pokeFlags:2'd0, seed:8'h22, newBase:32'h30000, expKind:2'd2},
    '{halt:1'b0, io:1'b0, pokeEn:1'b0, pokeFlags:2'd0, seed:8'h33, newBase:32'h30000, expKind:2'd0},
    '{halt:1'b1, io:1'b1, pokeEn:1'b0, pokeFlags:2'd0, seed:8'h44, newBase:32'h50000, expKind:2'd1},
    '{halt:1'b0, io:1'b0, pokeEn:1'b1, pokeFlags:2'd2, seed:8'h55, newBase:32'hA0000, expKind:2'd2},
    '{halt:1'b1, io:1'b0, pokeEn:1'b1, pokeFlags:2'd0, seed:8'h66, newBase:32'h30000, expKind:2'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic smiIn = 1'b0, resumeStb = 1'b0, haltIn = 1'b0, ioTrapIn = 1'b0;
  logic [7:0] seedB = 8'h00;
  logic [4:0] snapIdx, restoreIdx;
  logic [31:0] snapData, memAddr, memWdata, restoreData;
  logic [31:0] memRdata = 32'h0;
  logic memWe, memRe, restoreValid, inSmm, redirValid, resumeDone, resumeErr;
  logic [15:0] redirCs, redirIp;
  logic [1:0] resumeKind;

  logic [31:0] mem [logic [31:0]];
  logic [31:0] recExp [REC];
  logic [31:0] curBase = 32'h30000;
  int nTests = 0, nFail = 0, resvHits = 0;

  always #2 clk = ~clk;

  assign snapData = {8'h5A, seedB, 11'h0, snapIdx};

  smi_seq i_smi_seq (
    .clk(clk), .rstN(rstN), .smiIn(smiIn), .resumeStb(resumeStb),
    .haltIn(haltIn), .ioTrapIn(ioTrapIn), .snapIdx(snapIdx), .snapData(snapData),
    .memAddr(memAddr), .memWe(memWe), .memRe(memRe), .memWdata(memWdata),
    .memRdata(memRdata), .restoreValid(restoreValid), .restoreIdx(restoreIdx),
    .restoreData(restoreData), .inSmm(inSmm), .redirValid(redirValid),
    .redirCs(redirCs), .redirIp(redirIp), .resumeDone(resumeDone),
    .resumeKind(resumeKind), .resumeErr(resumeErr)
  );

  // state RAM model: one cycle read latency
  always @(posedge clk) begin
    if (memWe) begin
      if (memAddr >= curBase + 32'hFE00 && memAddr <= curBase + 32'hFEF7) resvHits++;
      mem[memAddr] = memWdata;
    end
    if (memRe) memRdata <= mem.exists(memAddr) ? mem[memAddr] : 32'hDEADBEEF;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] recAddr(input logic [31:0] b, input int k);
    return b + 32'h10000 - 32'((k + 1) * 4);
  endfunction

  task automatic doEntry(input logic halt, input logic io, input logic [7:0] seed, input bit already);
    if (!already) begin
      @(negedge clk);
      haltIn = halt; ioTrapIn = io; seedB = seed; smiIn = 1'b1;
      @(negedge clk);
      smiIn = 1'b0;
    end
    recExp[0] = {30'h0, io, halt};
    for (int k = 1; k < REC; k++) recExp[k] = {8'h5A, seed, 11'h0, 5'(k)};
    chk("R1 inSmm after accept", {31'h0, inSmm}, 32'h1);
    for (int k = 0; k < REC; k++) begin
      chk("R2 save write enable", {31'h0, memWe}, 32'h1);
      chk("R2 save address", memAddr, recAddr(curBase, k));
      chk("R2 save data", memWdata, recExp[k]);
      @(negedge clk);
    end
    chk("R3 base field write", {31'h0, memWe}, 32'h1);
    chk("R3 base field address", memAddr, curBase + 32'hFEF8);
    chk("R3 base field data", memWdata, curBase);
    @(negedge clk);
    chk("R4 redirect valid", {31'h0, redirValid}, 32'h1);
    chk("R4 redirect segment", {16'h0, redirCs}, {16'h0, curBase[19:4]});
    chk("R4 redirect pointer", {16'h0, redirIp}, 32'h8000);
    @(negedge clk);
    chk("R4 redirect single cycle", {31'h0, redirValid}, 32'h0);
    chk("R1 still in mode", {31'h0, inSmm}, 32'h1);
  endtask

  task automatic doResume(input logic [1:0] expKind, input logic [31:0] newBase, input bit pend);
    @(negedge clk);
    resumeStb = 1'b1;
    @(negedge clk);
    resumeStb = 1'b0;
    for (int k = 0; k < REC; k++) begin
      chk("R6 record read enable", {31'h0, memRe}, 32'h1);
      chk("R6 record read address", memAddr, recAddr(curBase, k));
      if (k > 0) begin
        chk("R6 restore valid", {31'h0, restoreValid}, 32'h1);
        chk("R6 restore index", {27'h0, restoreIdx}, 32'(k - 1));
        chk("R6 restore data", restoreData, recExp[k - 1]);
      end
      @(negedge clk);
    end
    chk("R10 base field read at old base", memAddr, curBase + 32'hFEF8);
    chk("R6 base read enable", {31'h0, memRe}, 32'h1);
    chk("R6 last restore data", restoreData, recExp[REC - 1]);
    @(negedge clk);
    chk("R6 resume done", {31'h0, resumeDone}, 32'h1);
    case (expKind)
      2'd1: chk("R7 kind halt", {30'h0, resumeKind}, 32'h1);
      2'd2: chk("R8 kind io", {30'h0, resumeKind}, 32'h2);
      default: chk("R9 kind continue", {30'h0, resumeKind}, 32'h0);
    endcase
    @(negedge clk);
    curBase = newBase;
    if (pend) begin
      chk("R12 no gap in mode", {31'h0, inSmm}, 32'h1);
      chk("R12 resave starts", {31'h0, memWe}, 32'h1);
      chk("R12 resave at new base", memAddr, recAddr(curBase, 0));
    end else begin
      chk("R1 mode left after resume", {31'h0, inSmm}, 32'h0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog all actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R13 reset state
    chk("R13 inSmm", {31'h0, inSmm}, 32'h0);
    chk("R13 memWe", {31'h0, memWe}, 32'h0);
    chk("R13 memRe", {31'h0, memRe}, 32'h0);
    chk("R13 redirValid", {31'h0, redirValid}, 32'h0);
    chk("R13 resumeDone", {31'h0, resumeDone}, 32'h0);
    chk("R13 resumeErr", {31'h0, resumeErr}, 32'h0);

    foreach (VECS[i]) begin
      doEntry(VECS[i].halt, VECS[i].io, VECS[i].seed, 1'b0);
      if (VECS[i].pokeEn) begin
        mem[recAddr(curBase, 0)] = {30'h0, VECS[i].pokeFlags};
        recExp[0] = {30'h0, VECS[i].pokeFlags};
      end
      mem[curBase + 32'hFEF8] = VECS[i].newBase;
      doResume(VECS[i].expKind, VECS[i].newBase, 1'b0);
    end

    // R12: a request held across a visit, base moved at the same time
    doEntry(1'b0, 1'b0, 8'h77, 1'b0);
    @(negedge clk);
    smiIn = 1'b1;
    @(negedge clk);
    smiIn = 1'b0;
    chk("R12 held request keeps mode", {31'h0, memWe}, 32'h0);
    haltIn = 1'b0; ioTrapIn = 1'b1; seedB = 8'h88;
    mem[curBase + 32'hFEF8] = 32'h70000;
    doResume(2'd0, 32'h70000, 1'b1);
    doEntry(1'b0, 1'b1, 8'h88, 1'b1);
    mem[curBase + 32'hFEF8] = 32'h30000;
    doResume(2'd2, 32'h30000, 1'b0);

    // R11: resume outside the mode
    @(negedge clk);
    resumeStb = 1'b1;
    @(negedge clk);
    resumeStb = 1'b0;
    chk("R11 no read", {31'h0, memRe}, 32'h0);
    chk("R11 no write", {31'h0, memWe}, 32'h0);
    chk("R11 mode stays low", {31'h0, inSmm}, 32'h0);
    chk("R11 error set", {31'h0, resumeErr}, 32'h1);
    repeat (3) @(negedge clk);
    chk("R11 error sticky", {31'h0, resumeErr}, 32'h1);

    chk("R5 reserved span writes", 32'(resvHits), 32'h0);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule